// File: doc/BRIEF.md
# Cartridge Bank Mapper with RAM Mirroring

This block sits between the CPU bus of an 8-bit console and the storage of a cartridge. It turns a 16-bit CPU address into a 20-bit ROM address and a 15-bit RAM address, and it asserts one chip select for each of the two memories. The ROM side is split into 4 KB windows. The seven windows from $8000 to $EFFF each have their own bank register, and a CPU write anywhere inside a window loads that register. The window from $F000 to $FFFF always shows the last ROM bank.

A control register sits at $FFFF. It picks which 16 KB half of a 32 KB RAM appears at $4000-$7FFF. It can also fold the RAM image by ignoring address line A8, A9 or both. A further bit limits that folding to the lower 8 KB of the RAM window.

Each access is classified by a combinational region decoder that uses an enumerated region type with five values:
- `RGN_NONE`: outside the cartridge.
- `RGN_RAM`: $4000-$7FFF.
- `RGN_BANKED`: $8000-$EFFF.
- `RGN_FIXED`: $F000-$FFFE.
- `RGN_CTRL`: $FFFF.

The only stored state is the seven bank registers and the control register. They do not pass through any sequence of states: each register simply takes its new value at the clock edge after a write that hits it. ROM and RAM addresses and chip selects follow the CPU address in the same cycle.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, every bank register and the control register are zero. A read at $8000-$EFFF gives rom_addr = {8'h00, cpu_addr[11:0]}, and RAM reads use the lower half with no folding.
- R2: A write (cpu_en=1, cpu_we=1) to any address in window $N000 (N = 8..E) stores cpu_wdata as that window's bank. From the next cycle, reads in that window give rom_addr = {bank, cpu_addr[11:0]}.
- R3: The seven bank registers are independent. A write in one window leaves the banks of the other six windows unchanged.
- R4: Reads in $F000-$FFFF always give rom_addr = {8'hFF, cpu_addr[11:0]}, whatever bank writes have taken place.
- R5: rom_cs is 1 only for reads (cpu_en=1, cpu_we=0) in $8000-$FFFF. Writes never assert rom_cs.
- R6: A write to $FFFF loads cpu_wdata into the control register and changes no bank. A write anywhere else in $F000-$FFFE has no effect on the control register or on any bank.
- R7: ram_addr[14] equals control bit 0, so bit 0 selects the lower or upper 16 KB half. ram_addr[13:0] equals cpu_addr[13:0] apart from folded lines.
- R8: When control bit 1 is set, ram_addr[8] is forced to 0 (A8 ignored). When control bit 2 is set, ram_addr[9] is forced to 0 (A9 ignored).
- R9: When control bit 4 is set, the folding of R8 applies only when cpu_addr[13]=0, which is the lower 8 KB of the RAM window.
- R10: ram_cs is 1 for any access with cpu_en=1 in $4000-$7FFF, and ram_we equals ram_cs AND cpu_we. Accesses below $4000 assert no chip select.
- R11: Control bit 3 is reserved and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_en | input | 1 | Bus cycle valid |
| cpu_we | input | 1 | Bus cycle is a write |
| rom_addr | output | 20 | Translated ROM byte address |
| rom_cs | output | 1 | ROM read select |
| ram_addr | output | 15 | Translated RAM byte address |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |

## Verification
All stored state is architectural, so a wrong bank register shows up on the upper eight bits of rom_addr at the first read of that window after the write. A stale or misdecoded control bit shows up on ram_addr[14], [9] or [8] at the next RAM read. The bench sweeps all 256 bank values across all seven windows, re-reading every window after each write, so a write that lands in the wrong register is caught one cycle later. It also sweeps all 32 control values against a spread of RAM offsets on both sides of the 8 KB boundary.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    localparam int CPU_AW    = 16;
    localparam int BANK_W    = 8;
    localparam int WIN_BITS  = 12;
    localparam int ROM_AW    = BANK_W + WIN_BITS;
    localparam int RAM_OFF_W = 14;
    localparam int RAM_AW    = RAM_OFF_W + 1;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_RAM,
        RGN_BANKED,
        RGN_FIXED,
        RGN_CTRL
    } region_e;

    // control register fields, bit positions follow the written data byte
    typedef struct packed {
        logic low_only;   // bit 4
        logic fold_a9;    // bit 2
        logic fold_a8;    // bit 1
        logic ram_upper;  // bit 0
    } mem_ctrl_t;

endpackage

// File: rtl/cart_region_decode.sv
module cart_region_decode
    import cart_map_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [CPU_AW-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  win_idx
);

    always_comb begin
        unique case (addr[15:12]) inside
            [4'h4:4'h7]: region = RGN_RAM;
            [4'h8:4'hE]: region = RGN_BANKED;
            4'hF:        region = (addr[11:0] == 12'hFFF) ? RGN_CTRL : RGN_FIXED;
            default:     region = RGN_NONE;
        endcase
    end

    // $8000 -> 0 ... $E000 -> 6
    assign win_idx = IDX_W'(addr[14:12]);

endmodule

// File: rtl/cart_bank_file.sv
module cart_bank_file #(
    parameter int NUM_WIN = 7,
    parameter int BANK_W  = 8,
    parameter int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rd_bank
);

    logic [BANK_W-1:0] bank_q [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[w] <= '0;
            else if (load && (idx == IDX_W'(w)))
                bank_q[w] <= wdata;
        end
    end

    always_comb begin
        rd_bank = '0;
        for (int w = 0; w < NUM_WIN; w++)
            if (idx == IDX_W'(w))
                rd_bank = bank_q[w];
    end

endmodule

// File: rtl/cart_ram_xlate.sv
module cart_ram_xlate
    import cart_map_pkg::*;
#(
    parameter int FOLD_LSB  = 8,
    parameter int NUM_FOLD  = 2,
    parameter int LOW_SPLIT = RAM_OFF_W - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_load,
    input  logic [BANK_W-1:0]    wdata,
    input  logic [RAM_OFF_W-1:0] offset,
    output logic [RAM_AW-1:0]    ram_addr
);

    mem_ctrl_t ctrl_q;
    logic [NUM_FOLD-1:0] fold_en;
    logic [RAM_OFF_W-1:0] folded;
    logic in_low;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_load)
            ctrl_q <= '{low_only: wdata[4], fold_a9: wdata[2],
                        fold_a8: wdata[1], ram_upper: wdata[0]};
    end

    assign in_low     = !offset[LOW_SPLIT];
    assign fold_en[0] = ctrl_q.fold_a8 && (!ctrl_q.low_only || in_low);
    assign fold_en[1] = ctrl_q.fold_a9 && (!ctrl_q.low_only || in_low);

    for (genvar b = 0; b < RAM_OFF_W; b++) begin : g_bit
        if (b >= FOLD_LSB && b < FOLD_LSB + NUM_FOLD) begin : g_fold
            assign folded[b] = offset[b] && !fold_en[b - FOLD_LSB];
        end else begin : g_pass
            assign folded[b] = offset[b];
        end
    end

    assign ram_addr = {ctrl_q.ram_upper, folded};

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
#(
    parameter int          NUM_WIN    = 7,
    parameter logic [7:0]  FIXED_BANK = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_en,
    input  logic              cpu_we,
    output logic [19:0]       rom_addr,
    output logic              rom_cs,
    output logic [14:0]       ram_addr,
    output logic              ram_cs,
    output logic              ram_we
);

    localparam int IDX_W = $clog2(NUM_WIN);

    region_e           region;
    logic [IDX_W-1:0]  win_idx;
    logic [BANK_W-1:0] cur_bank;
    logic              wr, rd;

    assign wr = cpu_en && cpu_we;
    assign rd = cpu_en && !cpu_we;

    cart_region_decode #(.IDX_W(IDX_W)) u_dec (
        .addr    (cpu_addr),
        .region  (region),
        .win_idx (win_idx)
    );

    cart_bank_file #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr && (region == RGN_BANKED)),
        .idx     (win_idx),
        .wdata   (cpu_wdata),
        .rd_bank (cur_bank)
    );

    cart_ram_xlate u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_load (wr && (region == RGN_CTRL)),
        .wdata     (cpu_wdata),
        .offset    (cpu_addr[RAM_OFF_W-1:0]),
        .ram_addr  (ram_addr)
    );

    always_comb begin
        rom_cs   = 1'b0;
        ram_cs   = 1'b0;
        rom_addr = {cur_bank, cpu_addr[WIN_BITS-1:0]};
        unique case (region)
            RGN_RAM:    ram_cs = cpu_en;
            RGN_BANKED: rom_cs = rd;
            RGN_FIXED,
            RGN_CTRL: begin
                rom_cs   = rd;
                rom_addr = {FIXED_BANK, cpu_addr[WIN_BITS-1:0]};
            end
            default: ;
        endcase
    end

    assign ram_we = ram_cs && cpu_we;

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_en,
    input logic        cpu_we,
    input logic [19:0] rom_addr,
    input logic        rom_cs,
    input logic [14:0] ram_addr,
    input logic        ram_cs,
    input logic        ram_we
);

    logic bank_wr;
    assign bank_wr = cpu_en && cpu_we && cpu_addr[15] && (cpu_addr[14:12] != 3'h7);

    assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> ((cpu_en && !cpu_we && cpu_addr[15:12] == $past(cpu_addr[15:12]))
                     -> rom_addr[19:12] == $past(cpu_wdata)));

    assert_rom_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> rom_addr[11:0] == cpu_addr[11:0]);

    assert_fixed_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs && cpu_addr[15:12] == 4'hF) |-> rom_addr[19:12] == 8'hFF);

    assert_no_rom_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && cpu_we) |-> !rom_cs);

    assert_ram_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> ram_addr[7:0] == cpu_addr[7:0]);

    assert_fold_only_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> ((ram_addr[9:8] & ~cpu_addr[9:8]) == 2'b00));

    assert_cs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rom_cs, ram_cs}) <= 1);

    assert_we_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && cpu_we));

endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (.*);

// File: tb/test_cart_bank_mapper.sv
`timescale 1ns/1ps
module test_cart_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_en = 1'b0;
    logic        cpu_we = 1'b0;
    logic [19:0] rom_addr;
    logic        rom_cs;
    logic [14:0] ram_addr;
    logic        ram_cs;
    logic        ram_we;

    int total = 0;
    int bad = 0;
    logic [7:0] bank_m [7];
    logic [7:0] ctrl_m;

    always #5 clk = ~clk;

    cart_bank_mapper i_cart_bank_mapper (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h addr=%h", req, act, exp, cpu_addr);
        end
    endtask

    task automatic bus_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_en = 1'b1; cpu_we = 1'b1;
        #1;
        check("R5 no rom_cs on write", rom_cs, 0);
        @(posedge clk);
        #1;
        cpu_en = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic bus_read(logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_en = 1'b1; cpu_we = 1'b0;
        #1;
    endtask

    function automatic logic [14:0] exp_ram(logic [15:0] a, logic [7:0] c);
        logic [13:0] off = a[13:0];
        logic ok = !c[4] || !off[13];
        if (c[1] && ok) off[8] = 1'b0;
        if (c[2] && ok) off[9] = 1'b0;
        return {c[0], off};
    endfunction

    task automatic check_windows(string req, logic [11:0] off);
        for (int w = 0; w < 7; w++) begin
            bus_read(16'h8000 + 16'(w << 12) + {4'h0, off});
            check(req, rom_addr, {bank_m[w], off});
            check({req, " rom_cs"}, rom_cs, 1);
        end
    endtask

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < 7; w++) bank_m[w] = 8'h00;
        ctrl_m = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_windows("R1 reset bank", 12'hABC);
        bus_read(16'h5321);
        check("R1 reset ram_addr", ram_addr, {1'b0, 14'h1321});
        check("R1 reset ram_cs", ram_cs, 1);

        // R2 / R3 sweep of all bank values over all windows
        for (int v = 0; v < 256; v++) begin
            int w = v % 7;
            logic [7:0] d = 8'(v) ^ 8'h5A;
            bus_write(16'h8000 + 16'(w << 12) + 16'((v * 37) & 12'hFFF), d);
            bank_m[w] = d;
            check_windows("R2 R3 bank readback", 12'((v * 13) & 12'hFFF));
        end

        // R4 fixed window
        for (int o = 0; o < 4096; o += 273) begin
            bus_read(16'hF000 + 16'(o));
            check("R4 fixed bank", rom_addr, {8'hFF, 12'(o)});
            check("R5 rom_cs fixed read", rom_cs, 1);
        end

        // R6 control write and ignored fixed-window writes
        bus_write(16'hFFFF, 8'h01);
        ctrl_m = 8'h01;
        bus_read(16'hFFFF);
        check("R6 ctrl addr reads rom", rom_addr, 20'hFFFFF);
        check_windows("R6 banks kept after ctrl write", 12'h123);
        bus_write(16'hF400, 8'h00);
        bus_write(16'hFFFE, 8'h00);
        bus_read(16'h4200);
        check("R6 fixed write ignored", ram_addr, exp_ram(16'h4200, ctrl_m));
        check_windows("R6 banks kept after fixed write", 12'h456);

        // R7 R8 R9 R11 sweep of all control values
        for (int c = 0; c < 32; c++) begin
            bus_write(16'hFFFF, 8'(c));
            ctrl_m = 8'(c);
            for (int o = 0; o < 16384; o += 97) begin
                bus_read(16'h4000 + 16'(o));
                check("R7 R8 R9 R11 ram_addr", ram_addr, exp_ram(16'h4000 + 16'(o), ctrl_m));
                check("R10 ram_cs read", {ram_cs, ram_we, rom_cs}, 3'b100);
            end
            bus_read(16'h6300);
            check("R9 upper 8K fold", ram_addr, exp_ram(16'h6300, ctrl_m));
            bus_read(16'h4300);
            check("R8 lower 8K fold", ram_addr, exp_ram(16'h4300, ctrl_m));
        end

        // R10 RAM write strobes and no decode below $4000
        @(negedge clk);
        cpu_addr = 16'h7FFF; cpu_en = 1'b1; cpu_we = 1'b1; cpu_wdata = 8'h11;
        #1;
        check("R10 ram write", {ram_cs, ram_we, rom_cs}, 3'b110);
        @(posedge clk); #1;
        cpu_en = 1'b0; cpu_we = 1'b0;
        bus_read(16'h3FFF);
        check("R10 below ram", {ram_cs, rom_cs}, 2'b00);
        bus_read(16'h0123);
        check("R10 low area", {ram_cs, rom_cs}, 2'b00);
        @(negedge clk);
        cpu_addr = 16'h5000; cpu_en = 1'b0;
        #1;
        check("R10 idle bus", {ram_cs, ram_we, rom_cs}, 3'b000);
        check_windows("R3 banks after ram traffic", 12'hFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule